// File: doc/BRIEF.md
# Flash DMA Transfer Sequencer

This block is the data-phase engine of a serial flash controller. Once chip select is active and the command and address bytes have gone out, software gives the engine a memory start address and a length word, which also carries the lane width. A write to the trigger register then picks the direction and starts the move. The engine either fetches bytes from system memory and shifts them onto the flash lanes, or collects bytes from the lanes and stores them to memory. Memory is reached through a byte-wide request/acknowledge port.

When the final byte has been handled, the engine sets a pending flag. Software clears this flag by writing one to it. The interrupt output is the flag gated by an enable bit in the configuration word. A busy bit in the status word tells software when a transfer is under way. A trigger that arrives while the engine is busy is dropped.

Bytes move back to back. A byte in the memory-to-flash direction costs its memory fetch and then its lane beats. A byte in the flash-to-memory direction costs its lane beats and then its memory store.

Top module: `flash_dma_seq`

## Requirements
- R1: After reset the configuration, address, length, pending and status words read zero, and `irq`, `mem_req` and `lane_en` are low.
- R2: Writing a value with bit 0 set to the trigger word (offset 0x18) starts a memory-to-flash move. Byte i is read from memory address start+i and then driven onto the lanes with `lane_oe` high, most significant bits first.
- R3: Writing a value with bit 0 clear to the trigger word starts a flash-to-memory move. Byte i is assembled from the lanes and written to memory address start+i.
- R4: Bits 29:28 of the length word (offset 0x24) select the lane width. Code 0 uses lane 0 only, 8 beats per byte. Code 1 uses lanes 1:0, 4 beats per byte. Codes 2 and 3 use lanes 3:0, 2 beats per byte. In every mode the higher lane carries the more significant bit of each beat.
- R5: The byte count is bits 11:0 of the length word. At trigger time the count is clipped to 2080 for flash-to-memory and to 520 for memory-to-flash.
- R6: Status bit 3 (offset 0x40) reads one from the cycle after an accepted trigger until the cycle in which the pending flag rises.
- R7: A trigger write while the engine is busy has no effect: it causes no extra memory access and no extra lane beat.
- R8: The pending flag is bit 0 at offset 0x20. It rises in the cycle after the last lane beat (memory-to-flash) or after the cycle in which memory acknowledges the last byte (flash-to-memory). No idle cycle falls between bytes, so each byte costs its lane beats plus the cycles its memory request is held.
- R9: Writing a one to pending bit 0 clears it, and writing a zero leaves it unchanged. If a clear and a completion land in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when the pending flag and configuration bit 20 (offset 0x00) are both set.
- R11: A clipped count of zero sets the pending flag in the cycle after the trigger, with no memory request and no lane beat.
- R12: The start address (offset 0x1C) reads back all 32 bits. The length word reads back only its count and lane-width fields, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Store data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Load data, valid with `mem_ack` |
| lane_en | output | 1 | A lane beat happens in this cycle |
| lane_oe | output | 1 | Beat drives the lanes (memory-to-flash) |
| lane_out | output | 4 | Outgoing lane bits |
| lane_in | input | 4 | Incoming lane bits, sampled on beats |

## Verification
Two events can meet in one cycle: the completion that sets the pending flag, and a software write of one to that same flag. The bench starts a one-byte, four-lane, memory-to-flash move, which takes exactly four cycles. It then times the clear write to land on the fourth edge, the one on which completion sets the flag. The test passes only if the flag reads set afterwards. In the same run, a trigger issued mid-transfer must leave the lane-beat and memory-store counts unchanged.

// File: rtl/flash_dma_pkg.sv
package flash_dma_pkg;

    localparam logic [7:0] OFS_CFG  = 8'h00;
    localparam logic [7:0] OFS_TRIG = 8'h18;
    localparam logic [7:0] OFS_ADDR = 8'h1C;
    localparam logic [7:0] OFS_PEND = 8'h20;
    localparam logic [7:0] OFS_LEN  = 8'h24;
    localparam logic [7:0] OFS_STAT = 8'h40;

    localparam int CFG_IE_BIT    = 20;
    localparam int STAT_BUSY_BIT = 3;
    localparam int LEN_WID_LSB   = 28;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEM_RD,
        ST_SHIFT_OUT,
        ST_SHIFT_IN,
        ST_MEM_WR
    } dma_state_e;

endpackage

// File: rtl/flash_dma_regs.sv
module flash_dma_regs
    import flash_dma_pkg::*;
#(
    parameter int RAW    = 8,
    parameter int DW     = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              busy,
    input  logic              done,
    output logic [DW-1:0]     reg_rdata,
    output logic              start,
    output logic              start_dir,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  cnt,
    output logic [1:0]        wid,
    output logic              pend,
    output logic              ie
);

    typedef struct packed {
        logic              ie;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        wid;
        logic              dir;
        logic              pend;
    } regs_t;

    regs_t q, d;

    logic hit_cfg, hit_trig, hit_addr, hit_pend, hit_len;

    assign hit_cfg   = reg_wr && (reg_addr == RAW'(OFS_CFG));
    assign hit_trig  = reg_wr && (reg_addr == RAW'(OFS_TRIG));
    assign hit_addr  = reg_wr && (reg_addr == RAW'(OFS_ADDR));
    assign hit_pend  = reg_wr && (reg_addr == RAW'(OFS_PEND));
    assign hit_len   = reg_wr && (reg_addr == RAW'(OFS_LEN));
    assign start     = hit_trig && !busy;
    assign start_dir = reg_wdata[0];

    always_comb begin
        d = q;
        if (hit_cfg)  d.ie = reg_wdata[CFG_IE_BIT];
        if (hit_addr) d.base = reg_wdata[ADDR_W-1:0];
        if (hit_len) begin
            d.cnt = reg_wdata[CNT_W-1:0];
            d.wid = reg_wdata[LEN_WID_LSB +: 2];
        end
        if (start) d.dir = reg_wdata[0];
        // a completion in the same cycle overrides the software clear
        if (hit_pend && reg_wdata[0]) d.pend = 1'b0;
        if (done) d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RAW'(OFS_CFG):  reg_rdata[CFG_IE_BIT] = q.ie;
            RAW'(OFS_TRIG): reg_rdata[0] = q.dir;
            RAW'(OFS_ADDR): reg_rdata[ADDR_W-1:0] = q.base;
            RAW'(OFS_PEND): reg_rdata[0] = q.pend;
            RAW'(OFS_LEN): begin
                reg_rdata[CNT_W-1:0] = q.cnt;
                reg_rdata[LEN_WID_LSB +: 2] = q.wid;
            end
            RAW'(OFS_STAT): reg_rdata[STAT_BUSY_BIT] = busy;
            default: reg_rdata = '0;
        endcase
    end

    assign base = q.base;
    assign cnt  = q.cnt;
    assign wid  = q.wid;
    assign pend = q.pend;
    assign ie   = q.ie;

endmodule

// File: rtl/flash_dma_lane.sv
module flash_dma_lane #(
    parameter int BYTE_W = 8,
    parameter int LANE_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_out,
    input  logic              start_in,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic [1:0]        wid,
    input  logic [LANE_N-1:0] lane_in,
    output logic [LANE_N-1:0] lane_out,
    output logic              lane_en,
    output logic              lane_oe,
    output logic              last,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam int CW = $clog2(BYTE_W);

    typedef struct packed {
        logic              active;
        logic              oe;
        logic [1:0]        wid;
        logic [CW-1:0]     cnt;
        logic [BYTE_W-1:0] sr;
    } lane_t;

    lane_t q, d;
    logic [CW-1:0]     last_idx;
    logic [BYTE_W-1:0] sr_shift;
    logic [LANE_N-1:0] out_bits;

    always_comb begin
        case (q.wid)
            2'd0: begin
                last_idx = CW'(BYTE_W - 1);
                sr_shift = {q.sr[BYTE_W-2:0], (q.oe ? 1'b0 : lane_in[0])};
                out_bits = {{(LANE_N-1){1'b0}}, q.sr[BYTE_W-1]};
            end
            2'd1: begin
                last_idx = CW'(BYTE_W / 2 - 1);
                sr_shift = {q.sr[BYTE_W-3:0], (q.oe ? 2'b00 : lane_in[1:0])};
                out_bits = {{(LANE_N-2){1'b0}}, q.sr[BYTE_W-1 -: 2]};
            end
            default: begin
                last_idx = CW'(BYTE_W / 4 - 1);
                sr_shift = {q.sr[BYTE_W-5:0], (q.oe ? 4'b0000 : lane_in[3:0])};
                out_bits = q.sr[BYTE_W-1 -: 4];
            end
        endcase
    end

    assign last = q.active && (q.cnt == last_idx);

    always_comb begin
        d = q;
        if (q.active) begin
            d.sr  = sr_shift;
            d.cnt = q.cnt + CW'(1);
            if (last) d.active = 1'b0;
        end
        if (start_out || start_in) begin
            d.active = 1'b1;
            d.oe     = start_out;
            d.wid    = wid;
            d.cnt    = '0;
            d.sr     = start_out ? load_byte : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lane_en  = q.active;
    assign lane_oe  = q.active && q.oe;
    assign lane_out = (q.active && q.oe) ? out_bits : '0;
    assign rx_byte  = q.sr;

endmodule

// File: rtl/flash_dma_ctrl.sv
module flash_dma_ctrl
    import flash_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12,
    parameter int BYTE_W = 8,
    parameter int RD_MAX = 2080,
    parameter int WR_MAX = 520
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_dir,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [1:0]        wid,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              lane_last,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              lane_start_out,
    output logic              lane_start_in,
    output logic [BYTE_W-1:0] lane_byte,
    output logic [1:0]        lane_wid,
    output logic              busy,
    output logic              done
);

    localparam logic [CNT_W-1:0] RD_LIM = CNT_W'(RD_MAX);
    localparam logic [CNT_W-1:0] WR_LIM = CNT_W'(WR_MAX);

    typedef struct packed {
        dma_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  remain;
        logic [1:0]        wid;
    } ctrl_t;

    ctrl_t q, d;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] eff_cnt;
    logic             final_byte;

    assign limit      = start_dir ? WR_LIM : RD_LIM;
    assign eff_cnt    = (cnt > limit) ? limit : cnt;
    assign final_byte = (q.remain == CNT_W'(1));

    always_comb begin
        d              = q;
        done           = 1'b0;
        mem_req        = 1'b0;
        mem_we         = 1'b0;
        lane_start_out = 1'b0;
        lane_start_in  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (eff_cnt == '0) begin
                        done = 1'b1;
                    end else begin
                        d.addr   = base;
                        d.remain = eff_cnt;
                        d.wid    = wid;
                        if (start_dir) begin
                            d.st = ST_MEM_RD;
                        end else begin
                            d.st          = ST_SHIFT_IN;
                            lane_start_in = 1'b1;
                        end
                    end
                end
            end
            ST_MEM_RD: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    lane_start_out = 1'b1;
                    d.st           = ST_SHIFT_OUT;
                end
            end
            ST_SHIFT_OUT: begin
                if (lane_last) begin
                    d.addr   = q.addr + ADDR_W'(1);
                    d.remain = q.remain - CNT_W'(1);
                    if (final_byte) begin
                        done = 1'b1;
                        d.st = ST_IDLE;
                    end else begin
                        d.st = ST_MEM_RD;
                    end
                end
            end
            ST_SHIFT_IN: begin
                if (lane_last) d.st = ST_MEM_WR;
            end
            ST_MEM_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    d.addr   = q.addr + ADDR_W'(1);
                    d.remain = q.remain - CNT_W'(1);
                    if (final_byte) begin
                        done = 1'b1;
                        d.st = ST_IDLE;
                    end else begin
                        lane_start_in = 1'b1;
                        d.st          = ST_SHIFT_IN;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, addr: '0, remain: '0, wid: '0};
        else        q <= d;
    end

    assign mem_addr  = q.addr;
    assign mem_wdata = rx_byte;
    assign lane_byte = mem_rdata;
    assign lane_wid  = (q.st == ST_IDLE) ? wid : q.wid;
    assign busy      = (q.st != ST_IDLE);

endmodule

// File: rtl/flash_dma_seq.sv
module flash_dma_seq
    import flash_dma_pkg::*;
#(
    parameter int RAW    = 8,
    parameter int DW     = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12,
    parameter int BYTE_W = 8,
    parameter int LANE_N = 4,
    parameter int RD_MAX = 2080,
    parameter int WR_MAX = 520
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              lane_en,
    output logic              lane_oe,
    output logic [LANE_N-1:0] lane_out,
    input  logic [LANE_N-1:0] lane_in
);

    logic              start, start_dir, busy, done, pend, ie;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        wid, lane_wid;
    logic              lane_start_out, lane_start_in, lane_last;
    logic [BYTE_W-1:0] lane_byte, rx_byte;

    flash_dma_regs #(
        .RAW(RAW), .DW(DW), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .busy(busy), .done(done),
        .reg_rdata(reg_rdata), .start(start), .start_dir(start_dir),
        .base(base), .cnt(cnt), .wid(wid), .pend(pend), .ie(ie)
    );

    flash_dma_ctrl #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W),
        .RD_MAX(RD_MAX), .WR_MAX(WR_MAX)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_dir(start_dir),
        .base(base), .cnt(cnt), .wid(wid),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .lane_last(lane_last), .rx_byte(rx_byte),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata),
        .lane_start_out(lane_start_out), .lane_start_in(lane_start_in),
        .lane_byte(lane_byte), .lane_wid(lane_wid),
        .busy(busy), .done(done)
    );

    flash_dma_lane #(
        .BYTE_W(BYTE_W), .LANE_N(LANE_N)
    ) u_lane (
        .clk(clk), .rst_n(rst_n),
        .start_out(lane_start_out), .start_in(lane_start_in),
        .load_byte(lane_byte), .wid(lane_wid), .lane_in(lane_in),
        .lane_out(lane_out), .lane_en(lane_en), .lane_oe(lane_oe),
        .last(lane_last), .rx_byte(rx_byte)
    );

    assign irq = pend && ie;

endmodule

// File: rtl/flash_dma_seq_chk.sv
module flash_dma_seq_chk
    import flash_dma_pkg::*;
#(
    parameter int RAW    = 8,
    parameter int DW     = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [RAW-1:0]    reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic              busy,
    input logic              done,
    input logic              pend,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              lane_en
);

    assert_busy_from_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && (reg_addr == RAW'(OFS_TRIG))));

    assert_end_sets_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> pend);

    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == RAW'(OFS_PEND)) && reg_wdata[0] && !done) |=> !pend);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> pend);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !lane_en));

    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_phase_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && lane_en));

endmodule

bind flash_dma_seq flash_dma_seq_chk #(
    .RAW(RAW), .DW(DW), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy), .done(done), .pend(pend),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .lane_en(lane_en)
);

// File: tb/tb_flash_dma_seq.sv
`timescale 1ns/1ps
module tb_flash_dma_seq;

    localparam logic [7:0] A_CFG  = 8'h00;
    localparam logic [7:0] A_TRIG = 8'h18;
    localparam logic [7:0] A_ADDR = 8'h1C;
    localparam logic [7:0] A_PEND = 8'h20;
    localparam logic [7:0] A_LEN  = 8'h24;
    localparam logic [7:0] A_STAT = 8'h40;

    // vector: [31] dir, [29:28] width code, [27:16] length, [11:0] start
    localparam int NVEC = 6;
    localparam logic [31:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 2'd0, 12'd3, 4'h0, 12'h040},
        {1'b1, 1'b0, 2'd1, 12'd5, 4'h0, 12'h081},
        {1'b1, 1'b0, 2'd2, 12'd9, 4'h0, 12'h200},
        {1'b0, 1'b0, 2'd0, 12'd4, 4'h0, 12'h300},
        {1'b0, 1'b0, 2'd1, 12'd6, 4'h0, 12'h313},
        {1'b0, 1'b0, 2'd3, 12'd7, 4'h0, 12'h400}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        lane_en, lane_oe;
    logic [3:0]  lane_out;
    logic [3:0]  lane_in;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] mem [4096];
    logic [7:0] fl_rx [2048];
    int  fl_nrx, fl_beat, fl_ph, wr_cnt;
    logic [7:0] fl_acc;
    logic mem_init = 1'b1;
    logic model_clr = 1'b0;
    int  tb_w = 0;
    int  tb_seed = 0;

    always #4 clk = ~clk;

    flash_dma_seq dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .lane_en(lane_en), .lane_oe(lane_oe), .lane_out(lane_out),
        .lane_in(lane_in)
    );

    function automatic int lanes_of(input int w);
        return (w == 0) ? 1 : (w == 1) ? 2 : 4;
    endfunction

    function automatic logic [7:0] mpat(input int a);
        return 8'(a * 13 + 5);
    endfunction

    function automatic logic [7:0] fpat(input int k, input int s);
        return 8'(k * 29 + 90 + s);
    endfunction

    function automatic logic [3:0] chunk_of(input logic [7:0] b, input int w, input int c);
        logic [7:0] s;
        s = b << (lanes_of(w) * c);
        case (lanes_of(w))
            1: return {3'b000, s[7]};
            2: return {2'b00, s[7:6]};
            default: return s[7:4];
        endcase
    endfunction

    // memory model: acknowledges one cycle after a request is seen
    always @(posedge clk) begin
        if (mem_init) begin
            for (int i = 0; i < 4096; i++) mem[i] <= mpat(i);
        end
        if (model_clr) wr_cnt <= 0;
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[11:0]];
            if (mem_we) begin
                mem[mem_addr[11:0]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    // flash model: supplies read beats, assembles written bytes
    always_comb lane_in = chunk_of(fpat(fl_beat / (8 / lanes_of(tb_w)), tb_seed),
                                   tb_w, fl_beat % (8 / lanes_of(tb_w)));

    always @(posedge clk) begin
        logic [7:0] acc_n;
        if (model_clr) begin
            fl_beat <= 0; fl_nrx <= 0; fl_ph <= 0; fl_acc <= '0;
        end else if (lane_en) begin
            if (lane_oe) begin
                case (lanes_of(tb_w))
                    1: acc_n = {fl_acc[6:0], lane_out[0]};
                    2: acc_n = {fl_acc[5:0], lane_out[1:0]};
                    default: acc_n = {fl_acc[3:0], lane_out};
                endcase
                fl_acc <= acc_n;
                if (fl_ph == 8 / lanes_of(tb_w) - 1) begin
                    fl_rx[fl_nrx[10:0]] <= acc_n;
                    fl_nrx <= fl_nrx + 1;
                    fl_ph <= 0;
                end else begin
                    fl_ph <= fl_ph + 1;
                end
            end else begin
                fl_beat <= fl_beat + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic run_xfer(input int dir, input int w, input int len, input int base,
                            input int seed, output int cyc);
        logic [31:0] r;
        reg_write(A_LEN, (32'(w) << 28) | 32'(len));
        reg_write(A_ADDR, 32'(base));
        tb_w = w; tb_seed = seed;
        @(negedge clk); model_clr = 1'b1;
        @(negedge clk); model_clr = 1'b0;
        reg_write(A_TRIG, 32'(dir));
        cyc = 0;
        reg_read(A_PEND, r);
        while (!r[0] && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            reg_read(A_PEND, r);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int cyc, bad, n, w, dir, base, bpb;
        repeat (3) @(negedge clk);
        mem_init = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        reg_read(A_CFG, r);  chk(r == 0, "R1 cfg", r, 0);
        reg_read(A_ADDR, r); chk(r == 0, "R1 addr", r, 0);
        reg_read(A_LEN, r);  chk(r == 0, "R1 len", r, 0);
        reg_read(A_PEND, r); chk(r == 0, "R1 pend", r, 0);
        reg_read(A_STAT, r); chk(r == 0, "R1 stat", r, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        chk(mem_req == 0, "R1 mem_req", mem_req, 0);
        chk(lane_en == 0, "R1 lane_en", lane_en, 0);

        // R12: readback
        reg_write(A_ADDR, 32'hDEAD_BEEF);
        reg_read(A_ADDR, r); chk(r == 32'hDEAD_BEEF, "R12 addr", r, 32'hDEAD_BEEF);
        reg_write(A_LEN, 32'h2000_0123);
        reg_read(A_LEN, r);  chk(r == 32'h2000_0123, "R12 len", r, 32'h2000_0123);
        reg_write(A_LEN, 32'hC3FF_F0AB);
        reg_read(A_LEN, r);  chk(r == 32'h0000_00AB, "R12 len mask", r, 32'h0000_00AB);

        // R2 R3 R4 R8: vector table
        for (int v = 0; v < NVEC; v++) begin
            dir = int'(VEC[v][31]);
            w = int'(VEC[v][29:28]);
            n = int'(VEC[v][27:16]);
            base = int'(VEC[v][11:0]);
            bpb = 8 / lanes_of(w);
            run_xfer(dir, w, n, base, v, cyc);
            chk(cyc == n * (bpb + 2), "R8 R4 completion cycle", cyc, n * (bpb + 2));
            bad = 0;
            if (dir == 1) begin
                if (fl_nrx != n) bad++;
                for (int k = 0; k < n; k++) if (fl_rx[k] != mpat(base + k)) bad++;
                chk(bad == 0, "R2 R4 memory-to-flash bytes", bad, 0);
            end else begin
                if (wr_cnt != n) bad++;
                for (int k = 0; k < n; k++) if (mem[base + k] != fpat(k, v)) bad++;
                chk(bad == 0, "R3 R4 flash-to-memory bytes", bad, 0);
            end
            reg_write(A_PEND, 32'h1);
        end

        // R5: clipping in both directions
        run_xfer(1, 2, 600, 12'h0A0, 0, cyc);
        chk(fl_nrx == 520, "R5 write clip bytes", fl_nrx, 520);
        chk(cyc == 520 * 4, "R5 write clip cycles", cyc, 520 * 4);
        reg_write(A_PEND, 32'h1);
        run_xfer(0, 2, 2100, 12'h600, 9, cyc);
        chk(wr_cnt == 2080, "R5 read clip bytes", wr_cnt, 2080);
        chk(cyc == 2080 * 4, "R5 read clip cycles", cyc, 2080 * 4);
        reg_write(A_PEND, 32'h1);

        // R11 R10 R9: zero length, interrupt gating, write-zero
        run_xfer(0, 0, 0, 12'h700, 0, cyc);
        chk(cyc == 0, "R11 zero length pending next cycle", cyc, 0);
        chk(wr_cnt == 0 && fl_beat == 0, "R11 no traffic", wr_cnt + fl_beat, 0);
        chk(irq == 0, "R10 irq masked", irq, 0);
        reg_write(A_CFG, 32'h0010_0000);
        chk(irq == 1, "R10 irq enabled", irq, 1);
        reg_write(A_PEND, 32'h0);
        reg_read(A_PEND, r); chk(r[0] == 1, "R9 write zero keeps pending", r[0], 1);
        reg_write(A_PEND, 32'h1);
        reg_read(A_PEND, r); chk(r[0] == 0, "R9 write one clears", r[0], 0);
        chk(irq == 0, "R10 irq follows pending", irq, 0);
        reg_write(A_CFG, 32'h0);

        // R6 R7 R9: busy, ignored trigger, clear colliding with completion
        reg_write(A_LEN, 32'h2000_0001);
        reg_write(A_ADDR, 32'h010);
        tb_w = 2; tb_seed = 0;
        @(negedge clk); model_clr = 1'b1;
        @(negedge clk); model_clr = 1'b0;
        reg_write(A_TRIG, 32'h1);
        reg_read(A_STAT, r); chk(r == 32'h8, "R6 busy after trigger", r, 32'h8);
        reg_write(A_TRIG, 32'h0);
        reg_write(A_PEND, 32'h1);
        reg_read(A_PEND, r); chk(r[0] == 1, "R9 completion wins over clear", r[0], 1);
        reg_read(A_STAT, r); chk(r == 0, "R6 busy cleared", r, 0);
        repeat (20) @(negedge clk);
        chk(fl_nrx == 1 && fl_rx[0] == mpat(12'h010), "R7 one byte only", fl_nrx, 1);
        chk(wr_cnt == 0 && fl_beat == 0, "R7 ignored trigger no read", wr_cnt + fl_beat, 0);
        reg_read(A_STAT, r); chk(r == 0, "R7 stays idle", r, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule